// File: doc/BRIEF.md
# Byte-Latched Down-Counting Timer

This block is one channel of a programmable down-counter that sits on a narrow processor bus. The counter is twice as wide as the bus, so software reads and writes it one byte at a time through a small register window. When the counter is enabled, each timer tick lowers it by one. A tick that arrives while the count is zero reloads the counter from a reload register and sets a sticky zero flag.

The difficulty is reading a running counter through a byte-wide port. The fix is a hidden holding register. A read of the count's low byte returns the live low byte. In the same access, it copies the live high byte into the holding register. A later read of the high byte returns that held copy. So a low-then-high pair of reads always gives a consistent snapshot, without stopping the counter.

Writes to the count take effect only while counting is disabled. Software clears the zero flag by reading the control register and then reading either count byte.

Top module: `byte_latched_timer`

## Requirements
- R1: After reset the count and reload registers read all ones, the enable bit is 0, the zero flag is 0 and the holding register is all ones.
- R2: A read at address 0 returns the live count low byte. In the same clock edge it copies the live count high byte into the holding register.
- R3: A read at address 1 returns the holding register's contents, not the live high byte. Reads that are not at address 0 leave the holding register unchanged.
- R4: While enabled, each cycle with tick high lowers a non-zero count by one. The count does not change when disabled or when tick is low.
- R5: A tick while enabled and at count zero loads the reload value into the counter and sets the zero flag on the next cycle.
- R6: Writes at address 0 (low byte) or address 1 (high byte) update that count byte only while the enable bit is 0, and can be done in either order. While enabled they are ignored.
- R7: Writes at address 2 (low byte) and address 3 (high byte) set the reload register at any time. Reads at those addresses return it.
- R8: The zero flag stays set until a count read (address 0 or 1) follows a control read made while the flag was set. A zero event in the clearing cycle keeps the flag set.
- R9: The control register is at address 4. Bit 0 is the enable bit (read/write) and bit 1 is the zero flag (read only). All other bits read 0.
- R10: While counting is disabled, a low-byte read still refreshes the holding register, so the following high-byte read returns the stopped high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count tick, one decrement per high cycle |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register |
| zero_flag | output | 1 | Sticky zero-reached flag |

## Verification
A stale or wrongly captured holding register shows up at the first high-byte read after a low-byte read. It gives a torn value, most visibly when the low byte wraps during the read pair. A counter that decrements or reloads wrongly shows on the next count read or on the zero flag, one cycle after the offending tick. An arming bit that is wrong shows as a flag that clears too early or stays stuck. The flag is compared against the reference model on every clock, so such faults appear within a cycle of the access that exposes them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int TMR_ADDR_W = 3;
   localparam int TMR_LANES  = 2;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_FLAG_BIT = 1;

   typedef enum logic [TMR_ADDR_W-1:0] {
      REG_CNT_LO = 3'd0,
      REG_CNT_HI = 3'd1,
      REG_REL_LO = 3'd2,
      REG_REL_HI = 3'd3,
      REG_CTRL   = 3'd4
   } tmr_reg_e;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctrl_wr,
   input  logic ctrl_wbit,
   input  logic ctrl_rd,
   input  logic cnt_rd,
   input  logic zero_evt,
   output logic run_en,
   output logic flag
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en <= 1'b0;
         flag   <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (ctrl_wr) run_en <= ctrl_wbit;
         if (zero_evt)
            flag <= 1'b1;
         else if (cnt_rd && armed)
            flag <= 1'b0;
         if (ctrl_rd)
            armed <= flag;
         else if (cnt_rd)
            armed <= 1'b0;
      end
   end

   assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> flag);
   assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed && cnt_rd && !zero_evt |=> !flag);
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !(armed && cnt_rd) |=> flag);
   assert_enable_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> run_en == $past(ctrl_wbit));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int DATA_W = 8,
   parameter int LANES  = 2,
   localparam int CW    = DATA_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              tick,
   input  logic [LANES-1:0]  cnt_wr,
   input  logic [LANES-1:0]  rel_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [CW-1:0]     count,
   output logic [CW-1:0]     reload,
   output logic              zero_evt
);
   assign zero_evt = run_en && tick && (count == '0);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_rel_lane
         logic [DATA_W-1:0] rel_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rel_q <= '1;
            else if (rel_wr[g]) rel_q <= wdata;
         end
         assign reload[g*DATA_W +: DATA_W] = rel_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '1;
      end else if (zero_evt) begin
         count <= reload;
      end else if (run_en && tick) begin
         count <= count - 1'b1;
      end else if (!run_en) begin
         for (int l = 0; l < LANES; l++)
            if (cnt_wr[l]) count[l*DATA_W +: DATA_W] <= wdata;
      end
   end

   assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && tick && count != '0 |=> count == $past(count) - 1'b1);
   assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_en && !tick |=> $stable(count));
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> count == $past(reload));
   assert_stopped_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en && cnt_wr == '0 |=> $stable(count));
endmodule

// File: rtl/tmr_readlatch.sv
module tmr_readlatch
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CW    = DATA_W * TMR_LANES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lo_rd,
   input  logic [TMR_ADDR_W-1:0] addr,
   input  logic [CW-1:0]         count,
   input  logic [CW-1:0]         reload,
   input  logic                  run_en,
   input  logic                  flag,
   output logic [DATA_W-1:0]     rdata
);
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold <= '1;
      else if (lo_rd) hold <= count[CW-1 -: DATA_W];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         REG_CNT_LO: rdata = count[DATA_W-1:0];
         REG_CNT_HI: rdata = hold;
         REG_REL_LO: rdata = reload[DATA_W-1:0];
         REG_REL_HI: rdata = reload[CW-1 -: DATA_W];
         REG_CTRL: begin
            rdata[CTRL_EN_BIT]   = run_en;
            rdata[CTRL_FLAG_BIT] = flag;
         end
         default: rdata = '0;
      endcase
   end

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lo_rd |=> hold == $past(count[CW-1 -: DATA_W]));
   assert_hold_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_rd |=> $stable(hold));
endmodule

// File: rtl/byte_latched_timer.sv
module byte_latched_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic [TMR_ADDR_W-1:0] bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  zero_flag
);
   localparam int CW = DATA_W * TMR_LANES;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must hold the enable and flag bits");
      end
   endgenerate

   logic [TMR_LANES-1:0] cnt_wr, rel_wr;
   logic                 ctrl_wr, ctrl_rd, cnt_rd, lo_rd;
   logic                 run_en, zero_evt;
   logic [CW-1:0]        count, reload;

   always_comb begin
      cnt_wr  = {bus_wr && bus_addr == REG_CNT_HI, bus_wr && bus_addr == REG_CNT_LO};
      rel_wr  = {bus_wr && bus_addr == REG_REL_HI, bus_wr && bus_addr == REG_REL_LO};
      ctrl_wr = bus_wr && bus_addr == REG_CTRL;
      ctrl_rd = bus_rd && bus_addr == REG_CTRL;
      lo_rd   = bus_rd && bus_addr == REG_CNT_LO;
      cnt_rd  = lo_rd || (bus_rd && bus_addr == REG_CNT_HI);
   end

   tmr_ctrl i_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
      .ctrl_wbit(bus_wdata[CTRL_EN_BIT]), .ctrl_rd(ctrl_rd), .cnt_rd(cnt_rd),
      .zero_evt(zero_evt), .run_en(run_en), .flag(zero_flag)
   );

   tmr_counter #(.DATA_W(DATA_W), .LANES(TMR_LANES)) i_counter (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
      .cnt_wr(cnt_wr), .rel_wr(rel_wr), .wdata(bus_wdata),
      .count(count), .reload(reload), .zero_evt(zero_evt)
   );

   tmr_readlatch #(.DATA_W(DATA_W)) i_latch (
      .clk(clk), .rst_n(rst_n), .lo_rd(lo_rd), .addr(bus_addr),
      .count(count), .reload(reload), .run_en(run_en), .flag(zero_flag),
      .rdata(bus_rdata)
   );
endmodule

// File: tb/test_byte_latched_timer.sv
`timescale 1ns/1ps
module test_byte_latched_timer;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, tick, bus_rd, bus_wr, zero_flag;
   logic [2:0]    bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;

   byte_latched_timer #(.DATA_W(DW)) i_byte_latched_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .zero_flag(zero_flag)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [15:0] m_cnt, m_rel;
   logic [7:0]  m_hold;
   logic        m_en, m_flag, m_arm;

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp_v);
      checks++;
      if (act !== exp_v) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
      end
   endtask

   function automatic logic [7:0] model_rd(input logic [2:0] a);
      case (a)
         3'd0: return m_cnt[7:0];
         3'd1: return m_hold;
         3'd2: return m_rel[7:0];
         3'd3: return m_rel[15:8];
         3'd4: return {6'b0, m_flag, m_en};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_update(input logic t, input logic r, input logic w,
                               input logic [2:0] a, input logic [7:0] d);
      logic zev, crd;
      zev = m_en && t && (m_cnt == 16'd0);
      crd = r && (a == 3'd0 || a == 3'd1);
      if (r && a == 3'd0) m_hold = m_cnt[15:8];
      if (zev) m_flag = 1'b1;
      else if (crd && m_arm) m_flag = 1'b0;
      if (r && a == 3'd4) m_arm = (m_flag && !zev) || (zev ? model_flag_before : 1'b0);
      else if (crd) m_arm = 1'b0;
      if (zev) m_cnt = m_rel;
      else if (m_en && t) m_cnt = m_cnt - 16'd1;
      else if (!m_en && w && a == 3'd0) m_cnt[7:0] = d;
      else if (!m_en && w && a == 3'd1) m_cnt[15:8] = d;
      if (w && a == 3'd2) m_rel[7:0] = d;
      if (w && a == 3'd3) m_rel[15:8] = d;
      if (w && a == 3'd4) m_en = d[0];
   endtask

   logic model_flag_before;

   task automatic step(input logic t, input logic r, input logic w,
                       input logic [2:0] a, input logic [7:0] d, input string req);
      tick = t; bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      if (r) check(req, "rdata", {8'h00, bus_rdata}, {8'h00, model_rd(a)});
      check("R5/R8", "zero_flag", {15'd0, zero_flag}, {15'd0, m_flag});
      @(posedge clk);
      model_flag_before = m_flag;
      model_update(t, r, w, a, d);
      #1;
   endtask

   task automatic rd(input logic [2:0] a, input logic t, input string req);
      step(t, 1'b1, 1'b0, a, 8'h00, req);
   endtask
   task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
      step(1'b0, 1'b0, 1'b1, a, d, req);
   endtask
   task automatic idle(input logic t, input int n, input string req);
      for (int i = 0; i < n; i++) step(t, 1'b0, 1'b0, 3'd0, 8'h00, req);
   endtask

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      bus_addr = 3'd0; bus_wdata = 8'h00;
      m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_hold = 8'hFF;
      m_en = 1'b0; m_flag = 1'b0; m_arm = 1'b0; model_flag_before = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state, R9 control format
      rd(3'd4, 1'b0, "R1/R9");
      rd(3'd1, 1'b0, "R1");
      rd(3'd0, 1'b0, "R1");
      rd(3'd2, 1'b0, "R1");
      rd(3'd3, 1'b0, "R1");
      // R6 stopped writes in either order; R3 stale hold before refresh
      wr(3'd1, 8'h03, "R6");
      wr(3'd0, 8'h05, "R6");
      rd(3'd1, 1'b0, "R3");
      rd(3'd0, 1'b0, "R10");
      rd(3'd1, 1'b0, "R10");
      // R7 reload lanes
      wr(3'd2, 8'h04, "R7");
      wr(3'd3, 8'h00, "R7");
      rd(3'd2, 1'b0, "R7");
      rd(3'd3, 1'b0, "R7");
      // R4 counting, R2/R3 reads while running
      wr(3'd4, 8'h01, "R9");
      idle(1'b1, 3, "R4");
      rd(3'd0, 1'b1, "R2");
      rd(3'd1, 1'b1, "R3");
      // R6 writes ignored while enabled
      wr(3'd0, 8'hAA, "R6");
      wr(3'd1, 8'hBB, "R6");
      rd(3'd0, 1'b0, "R6");
      rd(3'd1, 1'b0, "R6");
      // R2/R3 coherence across a low-byte wrap
      wr(3'd4, 8'h00, "R9");
      wr(3'd1, 8'h01, "R6");
      wr(3'd0, 8'h00, "R6");
      wr(3'd4, 8'h01, "R9");
      rd(3'd0, 1'b1, "R2");
      rd(3'd1, 1'b1, "R3");
      // R4 no counting while disabled
      wr(3'd4, 8'h00, "R9");
      idle(1'b1, 3, "R4");
      rd(3'd0, 1'b0, "R4");
      rd(3'd1, 1'b0, "R4");
      // R5 zero reload and flag; R8 clear sequence
      wr(3'd1, 8'h00, "R6");
      wr(3'd0, 8'h02, "R6");
      wr(3'd4, 8'h01, "R9");
      idle(1'b1, 3, "R5");
      rd(3'd0, 1'b0, "R5");
      rd(3'd1, 1'b0, "R8");
      rd(3'd4, 1'b0, "R8");
      idle(1'b0, 2, "R8");
      rd(3'd1, 1'b0, "R8");
      rd(3'd4, 1'b0, "R8");
      // R8 set wins over clear
      idle(1'b1, 5, "R5");
      idle(1'b1, 4, "R4");
      rd(3'd4, 1'b0, "R8");
      rd(3'd0, 1'b1, "R8");
      rd(3'd4, 1'b0, "R8");
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [2:0] a;
         a = 3'(i % 5);
         if (i % 7 == 3) step(1'b1, 1'b0, 1'b1, 3'd2, 8'(i), "R7");
         else step(1'b1 ^ (i % 3 == 0), 1'b1, 1'b0, a, 8'h00, "R2/R3");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule